// File: doc/BRIEF.md
# Four-Level Backplane Bus Arbiter

This block is the arbiter that a system-controller card places on a shared backplane bus. Requesters on the bus raise one of four request levels. The arbiter watches those levels and a bus-busy line, and it answers by raising exactly one of four grant lines. Each grant line feeds that level's daisy chain. The selection policy is picked at run time. It can serve level 3 alone, serve the highest pending level, or rotate fairly among the levels.

A grant is only offered while the bus is idle. The grant stays up until the new owner raises bus-busy. If nobody takes up a grant within a set number of cycles, the grant is withdrawn and a one-cycle interrupt pulse is raised. Under the priority policy, the arbiter raises a bus-clear line when a request arrives at a level above the current owner, so that the owner can release early. A strap pin, sampled only while reset is held, decides whether this card acts as arbiter at all.

Top module: `bpl_arb`

## Requirements
- R1: `ctrl_strap_n` is captured only while `rst` is high. A captured low enables arbitration. A captured high keeps `grant` at zero whatever the other inputs do, until the next reset captures a low.
- R2: From idle, a grant is issued only while `busy` is low and at least one level under consideration is requesting. The grant appears on the clock edge after the request is seen, with one bit set: bit i corresponds to level i.
- R3: An issued grant stays asserted until `busy` is seen high, and it drops on that same edge. No new grant is issued while `busy` stays high. After `busy` falls, arbitration resumes on the following edge.
- R4: With `mode_sel` = 0 (single level), only `req[3]` is considered, and requests on levels 0 to 2 are never granted.
- R5: With `mode_sel` = 1 (priority), the highest-numbered requesting level wins.
- R6: With `mode_sel` = 2 (rotating), the search starts one level below the last granted level and moves downward, wrapping from 0 to 3. The last granted level itself is tried last. Reset sets the last granted level to 0, so the first search starts at 3.
- R7: `mode_sel` = 3 selects exactly like priority mode, bus-clear included.
- R8: In priority modes, while a granted owner holds `busy` high, `clear_req` is high in the cycle after a request is seen at a level strictly above the owner's level. Otherwise it is low. This includes rotating or single mode, requests at or below the owner's level, and any time `busy` is low.
- R9: If a grant is held for `TIMEOUT` consecutive cycles without `busy` rising, the grant drops and `timeout_irq` is high for exactly one cycle, on the cycle after the grant falls.
- R10: After a timeout, the arbiter is idle again and may grant on the next edge. In rotating mode, the timed-out level counts as last granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the strap is captured while it is high |
| ctrl_strap_n | input | 1 | Controller-enable strap, low enables arbitration |
| mode_sel | input | 2 | Policy: 0 single level, 1 priority, 2 rotating, 3 priority |
| req | input | 4 | Request levels, active high, bit i is level i |
| busy | input | 1 | Bus busy, driven by the current owner |
| grant | output | 4 | Registered grant, at most one bit set |
| clear_req | output | 1 | Registered bus-clear to the current owner |
| timeout_irq | output | 1 | One-cycle pulse when an offered grant is withdrawn |

## Verification
Several properties are checked on every cycle: that at most one grant bit is set, that a grant only rises after a cycle with the bus idle, that a grant falls once busy is seen, and that bus-clear and the timeout pulse never coexist with a live grant. The timeout counter also never leaves its range. Which level actually wins under each policy, the rotating order carried across many grants, the exact grant length before a timeout, and the strap's effect can only be shown by the bench scenarios. Those scenarios sweep every request pattern under every mode value and track the last granted level arithmetically.

// File: rtl/bpl_arb_pkg.sv
package bpl_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_HELD  = 2'd2
  } arb_state_t;

  localparam logic [1:0] MODE_SINGLE = 2'd0;
  localparam logic [1:0] MODE_PRIO   = 2'd1;
  localparam logic [1:0] MODE_ROT    = 2'd2;
  localparam logic [1:0] MODE_PRIO2  = 2'd3;

  function automatic logic mode_is_prio(input logic [1:0] m);
    return (m == MODE_PRIO) || (m == MODE_PRIO2);
  endfunction

endpackage

// File: rtl/bpl_arb_select.sv
module bpl_arb_select
  import bpl_arb_pkg::*;
#(
  parameter int NLEV = 4,
  localparam int LVW = (NLEV > 1) ? $clog2(NLEV) : 1
) (
  input  logic [NLEV-1:0] req,
  input  logic [1:0]      mode,
  input  logic [LVW-1:0]  last_lvl,
  output logic            win_valid,
  output logic [LVW-1:0]  win_lvl
);

  logic            pr_valid, rr_valid;
  logic [LVW-1:0]  pr_lvl, rr_lvl;

  // highest-numbered requester wins
  always_comb begin
    pr_valid = 1'b0;
    pr_lvl   = '0;
    for (int i = 0; i < NLEV; i++) begin
      if (req[i]) begin
        pr_valid = 1'b1;
        pr_lvl   = LVW'(i);
      end
    end
  end

  // rotating: start one below last, go downward, wrap; last itself tried last
  always_comb begin
    rr_valid = 1'b0;
    rr_lvl   = '0;
    for (int k = 1; k <= NLEV; k++) begin
      int idx;
      idx = (int'(last_lvl) + NLEV - k) % NLEV;
      if (!rr_valid && req[idx]) begin
        rr_valid = 1'b1;
        rr_lvl   = LVW'(idx);
      end
    end
  end

  always_comb begin
    if (mode == MODE_SINGLE) begin
      win_valid = req[NLEV-1];
      win_lvl   = LVW'(NLEV-1);
    end else if (mode == MODE_ROT) begin
      win_valid = rr_valid;
      win_lvl   = rr_lvl;
    end else begin
      win_valid = pr_valid;
      win_lvl   = pr_lvl;
    end
  end

endmodule

// File: rtl/bpl_arb_timer.sv
module bpl_arb_timer #(
  parameter int LIMIT = 16,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expire
);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run) begin
      if (expire) cnt <= '0;
      else        cnt <= cnt + 1'b1;
    end
  end

  // R9: the count never reaches the limit itself
  assert_timer_range_R9: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(LIMIT));

endmodule

// File: rtl/bpl_arb.sv
module bpl_arb
  import bpl_arb_pkg::*;
#(
  parameter int NLEV    = 4,
  parameter int TIMEOUT = 16,
  localparam int LVW = (NLEV > 1) ? $clog2(NLEV) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctrl_strap_n,
  input  logic [1:0]      mode_sel,
  input  logic [NLEV-1:0] req,
  input  logic            busy,
  output logic [NLEV-1:0] grant,
  output logic            clear_req,
  output logic            timeout_irq
);

  arb_state_t     state;
  logic           ctrl_en;
  logic [LVW-1:0] owner_lvl, last_lvl, win_lvl;
  logic           win_valid, start, expire;
  logic [NLEV-1:0] above;

  bpl_arb_select #(.NLEV(NLEV)) u_sel (
    .req       (req),
    .mode      (mode_sel),
    .last_lvl  (last_lvl),
    .win_valid (win_valid),
    .win_lvl   (win_lvl)
  );

  assign start = (state == ST_IDLE) && ctrl_en && !busy && win_valid;

  bpl_arb_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .clr    (start),
    .run    ((state == ST_OFFER) && !busy),
    .expire (expire)
  );

  // levels strictly above the current owner
  always_comb begin
    for (int i = 0; i < NLEV; i++) above[i] = (LVW'(i) > owner_lvl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en     <= !ctrl_strap_n;
      state       <= ST_IDLE;
      grant       <= '0;
      owner_lvl   <= '0;
      last_lvl    <= '0;
      clear_req   <= 1'b0;
      timeout_irq <= 1'b0;
    end else begin
      timeout_irq <= 1'b0;
      clear_req   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            grant     <= NLEV'(1) << win_lvl;
            owner_lvl <= win_lvl;
            last_lvl  <= win_lvl;
            state     <= ST_OFFER;
          end
        end
        ST_OFFER: begin
          if (busy) begin
            grant <= '0;
            state <= ST_HELD;
          end else if (expire) begin
            grant       <= '0;
            timeout_irq <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        ST_HELD: begin
          if (!busy) state <= ST_IDLE;
          else clear_req <= mode_is_prio(mode_sel) && |(req & above);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: at most one grant line
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R2: a grant only rises after a cycle in which the bus was idle
  assert_grant_needs_idle_R2: assert property (@(posedge clk) disable iff (rst)
    ((|grant) && !$past(|grant)) |-> !$past(busy));

  // R3: busy seen while granted withdraws the grant
  assert_grant_drops_on_busy_R3: assert property (@(posedge clk) disable iff (rst)
    ((|grant) && busy) |=> (grant == '0));

  // R1: no grant when the strap disabled arbitration
  assert_strap_blocks_R1: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |-> (grant == '0));

  // R8: bus-clear never coexists with a live grant
  assert_clear_no_grant_R8: assert property (@(posedge clk) disable iff (rst)
    clear_req |-> (grant == '0));

  // R9: timeout pulse follows a withdrawn grant
  assert_timeout_after_grant_R9: assert property (@(posedge clk) disable iff (rst)
    timeout_irq |-> ((grant == '0) && $past(|grant)));

endmodule

// File: tb/sim_bpl_arb.sv
module sim_bpl_arb;

  localparam int TO = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic       strap_n;
  logic [1:0] mode;
  logic [3:0] req;
  logic       busy;
  logic [3:0] grant;
  logic       clear_req, timeout_irq;

  int vectors = 0;
  int errors  = 0;
  int last_m  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  bpl_arb #(.NLEV(4), .TIMEOUT(TO)) u0 (
    .clk          (clk),
    .rst          (rst),
    .ctrl_strap_n (strap_n),
    .mode_sel     (mode),
    .req          (req),
    .busy         (busy),
    .grant        (grant),
    .clear_req    (clear_req),
    .timeout_irq  (timeout_irq)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // independent model of the winner, returns -1 for none
  function automatic int model_pick(input int m, input logic [3:0] r, input int last);
    if (m == 0) return r[3] ? 3 : -1;
    if (m == 2) begin
      for (int k = 1; k <= 4; k++) begin
        int j;
        j = (last + 4 - k) % 4;
        if (r[j]) return j;
      end
      return -1;
    end
    for (int j = 3; j >= 0; j--) if (r[j]) return j;
    return -1;
  endfunction

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst = 1'b1; strap_n = s; req = '0; busy = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    last_m = 0;
  endtask

  // one arbitration round: request, check grant, take bus, release
  task automatic round(input int m, input logic [3:0] r, input string tag);
    int w;
    logic [3:0] e;
    w = model_pick(m, r, last_m);
    e = (w < 0) ? 4'b0000 : 4'(1 << w);
    mode = 2'(m); req = r; busy = 1'b0;
    @(negedge clk);
    chk(tag, grant, e);
    if (w >= 0) begin
      last_m = w;
      busy = 1'b1;
      @(negedge clk);
      chk("R3 grant dropped on busy", grant, 4'b0000);
      @(negedge clk);
      chk("R3 no regrant while busy", grant, 4'b0000);
    end
    req = '0; busy = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int n;
    rst = 1'b1; strap_n = 1'b0; mode = 2'd1; req = '0; busy = 1'b0;

    // R1: strap high at reset disables arbitration
    do_reset(1'b1);
    req = 4'b1000;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1 strap high blocks grant", grant, 4'b0000);
    end

    do_reset(1'b0);
    chk("R2 reset grant", grant, 4'b0000);
    chk("R8 reset clear", {3'b0, clear_req}, 4'b0);
    chk("R9 reset irq", {3'b0, timeout_irq}, 4'b0);

    // R2: busy high blocks a grant from idle
    mode = 2'd1; req = 4'b0100; busy = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R2 no grant while busy", grant, 4'b0000);
    req = '0; busy = 1'b0;
    @(negedge clk);

    // R4 R5 R6 R7: sweep every pattern under every mode, twice
    for (int m = 0; m < 4; m++) begin
      for (int rep = 0; rep < 2; rep++) begin
        for (int p = 0; p < 16; p++) begin
          case (m)
            0: round(m, 4'(p), "R4 single level pick");
            1: round(m, 4'(p), "R5 priority pick");
            2: round(m, 4'(p), "R6 rotating pick");
            default: round(m, 4'(p), "R7 alt priority pick");
          endcase
        end
      end
    end

    // R8: bus-clear cases
    for (int m = 0; m < 4; m++) begin
      for (int hi = 0; hi < 4; hi++) begin
        logic exp_c;
        do_reset(1'b0);
        mode = 2'(m); req = 4'b0010; busy = 1'b0;
        if (m == 0) req = 4'b1000;
        @(negedge clk);
        busy = 1'b1;
        @(negedge clk);
        req = 4'(1 << hi);
        @(negedge clk);
        exp_c = (m == 1 || m == 3) && (hi > 1);
        chk("R8 bus clear", {3'b0, clear_req}, {3'b0, exp_c});
        busy = 1'b0;
        @(negedge clk);
        chk("R8 clear low when bus idle", {3'b0, clear_req}, 4'b0);
        req = '0;
        @(negedge clk);
      end
    end

    // R9 R10: unanswered grant times out, rotation continues
    do_reset(1'b0);
    mode = 2'd2; req = 4'b0100; busy = 1'b0;
    n = 0;
    @(negedge clk);
    while (grant != 4'b0000 && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R9 grant length", 4'(n), 4'(TO));
    chk("R9 irq pulse", {3'b0, timeout_irq}, 4'b0001);
    req = 4'b0101;
    @(negedge clk);
    chk("R9 irq one cycle", {3'b0, timeout_irq}, 4'b0000);
    chk("R10 rotating after timeout", grant, 4'b0001);
    busy = 1'b1; req = '0;
    @(negedge clk);
    busy = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule